// File: doc/BRIEF.md
# Serial Converter Frame Controller

This block drives a three-wire serial sampling converter from a fast system clock. It produces the converter's serial clock and conversion strobe and shifts the returned serial data into a parallel word. Each finished word is offered on a valid/ready output, together with a flag that marks the word as belonging to a conversion started before the current run.

A small command port starts continuous conversion and sends the converter into one of two power-down states. In each power-down state the strobe is pulsed while the serial clock stays frozen low: two pulses for the light state and four for the deep state. A wake command sends one serial clock pulse and then waits through a parameterised settle interval before the block reports itself idle again. Commands are taken only at frame boundaries. A busy output covers the whole of each power sequence.

Each frame lasts eighteen serial clocks. Data bits arrive MSB first on the rising edges. The word is two's complement, either 14 or 12 bits wide, and the block sign-extends it to 16 bits.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: While reset is held and just after it, `sck`, `conv`, `out_valid`, `busy` and `powered_down` are low and `cmd_ready` is high.
- R2: In a run, one frame is 36 half periods of HALF_CYC system cycles each. That gives 18 rising `sck` edges per frame, and `conv` rises every 36*HALF_CYC cycles. `conv` is high for the first `sck` period and rises HALF_CYC cycles before the first `sck` rise of its frame.
- R3: With `narrow` low at frame start, `sdo` is sampled at rising `sck` edges 3 to 16 of the frame, MSB first. The 14-bit result is sign-extended from bit 13 onto `out_data`.
- R4: With `narrow` high at frame start, only rising edges 3 to 14 are used and the bits at edges 15 and 16 are discarded. The result is sign-extended from bit 11.
- R5: The first word delivered after leaving idle (after reset or after a wake) has `out_stale` high. Every later word in that run has it low.
- R6: `out_valid` stays high until `out_ready` is seen. A newer word replaces an unaccepted one, with `out_valid` still high.
- R7: `cmd_ready` is high only when idle, when powered down, or in the last system cycle of a frame. It is never high while `busy` is high. A run command while running, and any command other than wake while powered down, has no effect.
- R8: Command code 1 gives two `conv` pulses with `sck` low and `busy` high for 8*HALF_CYC cycles. After that `powered_down` is high.
- R9: Command code 2 gives four `conv` pulses with `sck` low and `busy` high for 16*HALF_CYC cycles. After that `powered_down` is high.
- R10: Command code 3 gives exactly one `sck` pulse with `conv` low, then SETTLE_CYC more cycles. `busy` covers 2*HALF_CYC+SETTLE_CYC cycles, after which the block is idle. Command code 0 starts the run.
- R11: Outside a run frame and the wake pulse, `sck` is low. While powered down, `conv` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code: 0 run, 1 light power-down, 2 deep power-down, 3 wake |
| cmd_ready | output | 1 | Command taken when high with cmd_valid |
| narrow | input | 1 | Selects 12-bit words; sampled at each frame start |
| sck | output | 1 | Serial clock to the converter |
| conv | output | 1 | Conversion strobe to the converter |
| sdo | input | 1 | Serial data from the converter |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | Sign-extended sample |
| out_stale | output | 1 | Word belongs to a conversion from before this run |
| busy | output | 1 | Power sequence or settle wait in progress |
| powered_down | output | 1 | Converter has been put into a power-down state |

## Verification
The hardest case to reach from the ports is a command that arrives while frames are running. It is accepted only in the single system cycle that closes a frame. The bench therefore holds `cmd_valid` at the inactive clock edge until `cmd_ready` appears, and this is how it lands a power-down request and a redundant run request exactly on a boundary. The overwrite case needs `out_ready` held low across two whole frames. Twelve-bit frames drive deliberately non-zero bits on edges 15 and 16 to show those edges are dropped.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_PWR,
        ST_DOWN,
        ST_WAKE,
        ST_SETTLE
    } st_e;

    typedef enum logic [1:0] {
        OP_RUN   = 2'd0,
        OP_NAP   = 2'd1,
        OP_SLEEP = 2'd2,
        OP_WAKE  = 2'd3
    } op_e;

    localparam int FRAME_SCKS    = 18;
    localparam int FRAME_HALVES  = 2 * FRAME_SCKS;
    localparam int LEAD_EDGES    = 2;
    localparam int NAP_PULSES    = 2;
    localparam int SLEEP_PULSES  = 4;
    localparam int OUT_W         = 16;

endpackage

// File: rtl/sadc_halftick.sv
module sadc_halftick #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
    parameter int RAW_W    = 14,
    parameter int NARROW_W = 12,
    parameter int OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdo,
    input  logic             narrow,
    output logic [OUT_W-1:0] word
);
    logic [RAW_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) sh_d = {sh_q[RAW_W-2:0], sdo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // shifted-in bits sit at the bottom; extend from the top valid bit
    always_comb begin
        if (narrow) word = {{(OUT_W-NARROW_W){sh_q[NARROW_W-1]}}, sh_q[NARROW_W-1:0]};
        else        word = {{(OUT_W-RAW_W){sh_q[RAW_W-1]}}, sh_q};
    end
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int HALF_CYC   = 2,
    parameter int SETTLE_CYC = 500000,
    parameter int RAW_W      = 14,
    parameter int NARROW_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    output logic             cmd_ready,
    input  logic             narrow,
    output logic             sck,
    output logic             conv,
    input  logic             sdo,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_stale,
    output logic             busy,
    output logic             powered_down
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [5:0] LAST_HALF    = 6'(FRAME_HALVES - 1);
    // edge e rises entering half 2e-1, so it is sampled while half 2e-2 ends
    localparam logic [5:0] FIRST_SAMPLE = 6'(2 * (LEAD_EDGES + 1) - 2);
    localparam logic [5:0] LAST_WIDE    = 6'(2 * (LEAD_EDGES + RAW_W) - 2);
    localparam logic [5:0] LAST_NARROW  = 6'(2 * (LEAD_EDGES + NARROW_W) - 2);
    localparam logic [5:0] DELIVER_HALF = 6'(2 * (LEAD_EDGES + RAW_W) - 1);
    localparam logic [5:0] NAP_LAST     = 6'(4 * NAP_PULSES - 1);
    localparam logic [5:0] SLEEP_LAST   = 6'(4 * SLEEP_PULSES - 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    typedef struct packed {
        st_e              st;
        logic [5:0]       half;
        logic [5:0]       plim;
        logic [SW-1:0]    settle;
        logic             narrow;
        logic             fresh;
        logic             sck;
        logic             conv;
        logic             vld;
        logic             stale;
        logic [OUT_W-1:0] data;
    } ctl_t;

    ctl_t q, d;
    logic tick, tick_en, shift_en, deliver, frame_end, take;
    logic [5:0] last_sample;
    logic [OUT_W-1:0] word;

    assign tick_en = (q.st == ST_RUN) || (q.st == ST_PWR) || (q.st == ST_WAKE);

    sadc_halftick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .tick(tick)
    );

    assign last_sample = q.narrow ? LAST_NARROW : LAST_WIDE;
    assign shift_en = (q.st == ST_RUN) && tick && !q.half[0]
                   && (q.half >= FIRST_SAMPLE) && (q.half <= last_sample);
    assign deliver  = (q.st == ST_RUN) && tick && (q.half == DELIVER_HALF);

    sadc_capture #(.RAW_W(RAW_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdo(sdo),
        .narrow(q.narrow), .word(word)
    );

    assign frame_end = (q.st == ST_RUN) && tick && (q.half == LAST_HALF);
    assign cmd_ready = (q.st == ST_IDLE) || (q.st == ST_DOWN) || frame_end;
    assign take      = cmd_valid && cmd_ready;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (take) begin
                    d.half = '0;
                    case (cmd_op)
                        OP_RUN:   begin d.st = ST_RUN; d.narrow = narrow; end
                        OP_NAP:   begin d.st = ST_PWR; d.plim = NAP_LAST;   end
                        OP_SLEEP: begin d.st = ST_PWR; d.plim = SLEEP_LAST; end
                        default:  d.st = ST_WAKE;
                    endcase
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (q.half == LAST_HALF) begin
                        d.half   = '0;
                        d.narrow = narrow;
                        if (take && cmd_op == OP_NAP) begin
                            d.st = ST_PWR; d.plim = NAP_LAST;
                        end else if (take && cmd_op == OP_SLEEP) begin
                            d.st = ST_PWR; d.plim = SLEEP_LAST;
                        end
                    end else begin
                        d.half = q.half + 6'd1;
                    end
                end
            end
            ST_PWR: begin
                if (tick) begin
                    if (q.half == q.plim) begin d.st = ST_DOWN; d.half = '0; end
                    else d.half = q.half + 6'd1;
                end
            end
            ST_DOWN: begin
                if (take && cmd_op == OP_WAKE) begin d.st = ST_WAKE; d.half = '0; end
            end
            ST_WAKE: begin
                if (tick) begin
                    if (q.half == 6'd1) begin d.st = ST_SETTLE; d.settle = '0; end
                    else d.half = q.half + 6'd1;
                end
            end
            ST_SETTLE: begin
                if (q.settle == SETTLE_LAST) begin d.st = ST_IDLE; d.fresh = 1'b1; end
                else d.settle = q.settle + SW'(1);
            end
            default: d.st = ST_IDLE;
        endcase

        if (q.vld && out_ready) d.vld = 1'b0;
        if (deliver) begin
            d.vld   = 1'b1;
            d.data  = word;
            d.stale = q.fresh;
            d.fresh = 1'b0;
        end

        d.sck  = ((d.st == ST_RUN) && d.half[0]) || ((d.st == ST_WAKE) && (d.half == 6'd0));
        d.conv = ((d.st == ST_RUN) && (d.half < 6'd2)) || ((d.st == ST_PWR) && !d.half[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.fresh <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck          = q.sck;
    assign conv         = q.conv;
    assign out_valid    = q.vld;
    assign out_data     = q.data;
    assign out_stale    = q.stale;
    assign busy         = (q.st == ST_PWR) || (q.st == ST_WAKE) || (q.st == ST_SETTLE);
    assign powered_down = (q.st == ST_DOWN);
endmodule

// File: rtl/sadc_frame_ctrl_chk.sv
module sadc_frame_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        sck,
    input logic        conv,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_data,
    input logic        busy,
    input logic        powered_down
);
    // R2: the strobe always rises while the serial clock is low
    assert_conv_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv) |-> !sck);

    // R3: the upper three bits of a delivered word agree
    assert_sign_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_data[15:13]) == 0 || $countones(out_data[15:13]) == 3));

    // R6: an unaccepted word is not withdrawn
    assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);

    // R7: no command is offered during a power sequence
    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !busy);

    // R8: strobe pulses during a power sequence see a frozen clock
    assert_frozen_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && conv |-> !sck);

    // R10: the wake clock pulse carries no strobe
    assert_wake_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sck |-> !conv);

    // R11: both converter lines rest while powered down
    assert_down_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        powered_down |-> !sck && !conv);
endmodule

bind sadc_frame_ctrl sadc_frame_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .sck(sck), .conv(conv),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .powered_down(powered_down)
);

// File: tb/sadc_frame_ctrl_test.sv
`timescale 1ns/1ps
module sadc_frame_ctrl_test;
    localparam int HALF   = 2;
    localparam int SETTLE = 40;
    localparam int NVEC   = 8;
    // {narrow, raw 14 bits as sent MSB first, expected 16-bit word}
    localparam logic [30:0] TAB [NVEC] = '{
        {1'b0, 14'h1FFF, 16'h1FFF},
        {1'b0, 14'h2000, 16'hE000},
        {1'b0, 14'h3FFF, 16'hFFFF},
        {1'b1, 14'h1FFF, 16'h07FF},
        {1'b1, 14'h2001, 16'hF800},
        {1'b0, 14'h0000, 16'h0000},
        {1'b1, 14'h2972, 16'hFA5C},
        {1'b0, 14'h1555, 16'h1555}
    };

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, narrow = 0, sdo = 0, out_ready = 1;
    logic [1:0] cmd_op = 0;
    logic cmd_ready, sck, conv, out_valid, out_stale, busy, powered_down;
    logic [15:0] out_data;

    sadc_frame_ctrl #(.HALF_CYC(HALF), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .narrow(narrow), .sck(sck), .conv(conv), .sdo(sdo),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_stale(out_stale), .busy(busy), .powered_down(powered_down)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int conv_rises = 0, sck_rises = 0, conv_base = 0, sck_base = 0;
    int fidx = -1, edge_n = 0, edges_last = 0, conv_cyc = 0, period = 0, lead = 0;
    bit frames_on = 0;
    logic [30:0] cur = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // converter model
    always @(posedge conv) begin
        #1;
        conv_rises++;
        if (frames_on) begin
            edges_last = edge_n;
            if (fidx >= 0) period = cyc - conv_cyc;
            conv_cyc = cyc;
            fidx++;
            cur = TAB[fidx % NVEC];
            edge_n = 0;
            sdo = 1'b0;
            narrow = TAB[(fidx + 1) % NVEC][30];
        end
    end

    always @(posedge sck) begin
        #1;
        sck_rises++;
        if (frames_on) begin
            edge_n++;
            if (edge_n == 1) lead = cyc - conv_cyc;
            if (edge_n + 1 >= 3 && edge_n + 1 <= 16) sdo = cur[16 + 16 - (edge_n + 1)];
            else sdo = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // on: 1 frames start, 0 frames stop, -1 unchanged
    task automatic send_cmd(input logic [1:0] op, input int on);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op;
        while (!cmd_ready) @(negedge clk);
        if (on >= 0) frames_on = (on != 0);
        conv_base = conv_rises; sck_base = sck_rises;
        @(posedge clk); #1 cmd_valid = 0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (busy) n++; else break;
        end
    endtask

    task automatic wait_word;
        do @(negedge clk); while (!out_valid);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, f1;
        narrow = TAB[0][30];
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "sck", sck, 0);
        chk("R1", "conv", conv, 0);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "powered_down", powered_down, 0);
        chk("R1", "cmd_ready", cmd_ready, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1", "cmd_ready after reset", cmd_ready, 1);

        // vector walk: R3 wide words, R4 narrow words, R5 stale flag
        send_cmd(2'd0, 1);
        for (int i = 0; i < NVEC; i++) begin
            wait_word;
            chk(TAB[fidx % NVEC][30] ? "R4" : "R3", "word", out_data, TAB[fidx % NVEC][15:0]);
            chk("R5", "stale", out_stale, (i == 0) ? 1 : 0);
        end
        chk("R2", "frame period", period, 36 * HALF);
        chk("R2", "conv lead", lead, HALF);
        chk("R2", "sck edges per frame", edges_last, 18);

        // R7 redundant run at a boundary
        send_cmd(2'd0, 1);
        wait_word;
        chk("R7", "run while running stale", out_stale, 0);
        chk("R7", "run while running word", out_data, TAB[fidx % NVEC][15:0]);
        chk("R7", "busy", busy, 0);

        // R6 overwrite while stalled
        out_ready = 0;
        wait_word;
        f1 = fidx;
        while (fidx != f1 + 2) @(negedge clk);
        chk("R6", "valid held", out_valid, 1);
        chk("R6", "newer word", out_data, TAB[(f1 + 1) % NVEC][15:0]);
        chk("R6", "stale", out_stale, 0);
        out_ready = 1;
        @(negedge clk);
        chk("R6", "valid dropped", out_valid, 0);

        // R8 light power-down
        send_cmd(2'd1, 0);
        busy_len(n);
        chk("R8", "busy cycles", n, 8 * HALF);
        chk("R8", "conv pulses", conv_rises - conv_base, 2);
        chk("R8", "sck pulses", sck_rises - sck_base, 0);
        chk("R8", "powered_down", powered_down, 1);

        // R7 / R11 run request while down is ignored
        send_cmd(2'd0, -1);
        repeat (50) @(negedge clk);
        chk("R7", "conv while down", conv_rises - conv_base, 0);
        chk("R11", "sck while down", sck_rises - sck_base, 0);
        chk("R7", "still down", powered_down, 1);
        chk("R7", "no word", out_valid, 0);

        // R10 wake
        send_cmd(2'd3, -1);
        busy_len(n);
        chk("R10", "busy cycles", n, 2 * HALF + SETTLE);
        chk("R10", "sck pulses", sck_rises - sck_base, 1);
        chk("R10", "conv pulses", conv_rises - conv_base, 0);
        chk("R10", "idle after settle", powered_down, 0);
        chk("R10", "cmd_ready", cmd_ready, 1);

        // R5 fresh run after wake
        narrow = TAB[(fidx + 1) % NVEC][30];
        send_cmd(2'd0, 1);
        wait_word;
        chk("R5", "first word stale", out_stale, 1);
        chk(TAB[fidx % NVEC][30] ? "R4" : "R3", "word after wake", out_data, TAB[fidx % NVEC][15:0]);
        wait_word;
        chk("R5", "second word", out_stale, 0);

        // R9 deep power-down
        send_cmd(2'd2, 0);
        busy_len(n);
        chk("R9", "busy cycles", n, 16 * HALF);
        chk("R9", "conv pulses", conv_rises - conv_base, 4);
        chk("R9", "sck pulses", sck_rises - sck_base, 0);
        chk("R9", "powered_down", powered_down, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule